// File: doc/BRIEF.md
# Conversion and Computation Cycle Sequencer

This block produces the timing and status flow for a two-channel sampling front end. It divides the master clock by a programmable prescale value K to make a prescaled tick. It derives two strobes from that tick: a modulator sample strobe every 8 ticks and a slower conversion (output-word) strobe every `WORD_DIV` ticks, 1024 by default.

A programmable cycle length N groups conversions into computation cycles. The block raises a cycle strobe on the conversion that closes each group. The two strobes set two sticky status bits. Bit 0 is conversion-ready and bit 1 is cycle-ready. Software clears them by writing ones to their positions. An enable mask, where a 1 unmasks the bit, selects which set bits pull the active-low interrupt output low.

With a 4.096 MHz master clock and the reset values (K = 1, N = 4000), conversions come at 4000 Hz and computation cycles at 1 Hz.

Top module: `conversion_sequencer`

## Requirements
- R1: `sample_stb` is a one-clock pulse repeating every 8·Keff clocks, where Keff is K, or 1 when K is 0.
- R2: `conv_stb` is a one-clock pulse repeating every `WORD_DIV`·Keff clocks, and it always coincides with a `sample_stb` pulse. Writing K restarts the prescaler, and a K of 0 behaves as 1.
- R3: A `conv_stb` pulse sets `status[0]`, which reads 1 from the following clock onward.
- R4: `cycle_stb` pulses together with every Neff-th `conv_stb`, where Neff is N, or 1 when N is 0. The same edge that follows the pulse sets `status[1]`.
- R5: With N = 1 or N = 0, `cycle_stb` accompanies every `conv_stb`.
- R6: Writing N restarts the conversion count, so the first `cycle_stb` after the write comes on the Neff-th conversion after it.
- R7: A write with `clr_wr` clears each status bit whose `clr_wdata` position is 1 and leaves the other bit unchanged. A set and a clear of the same bit in the same clock leave the bit set.
- R8: `irq_n` is registered: one clock after `status & irq_en` is nonzero it reads 0, and one clock after it is zero it reads 1.
- R9: Synchronous reset clears both status bits and `irq_en`, drives `irq_n` high, and loads K = `KDEF` (1) and N = `NDEF` (4000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| k_wr | input | 1 | Load prescale value |
| k_wdata | input | KW | New prescale value K |
| n_wr | input | 1 | Load cycle length |
| n_wdata | input | NW | New cycle length N |
| mask_wr | input | 1 | Load interrupt enable mask |
| mask_wdata | input | 2 | New enable mask (1 = unmasked) |
| clr_wr | input | 1 | Write-one-to-clear strobe for status |
| clr_wdata | input | 2 | Status bits to clear |
| sample_stb | output | 1 | Modulator sample strobe |
| conv_stb | output | 1 | Conversion strobe |
| cycle_stb | output | 1 | Computation-cycle strobe |
| status | output | 2 | Sticky status: bit 0 conversion-ready, bit 1 cycle-ready |
| irq_en | output | 2 | Current enable mask |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with `WORD_DIV` = 32 and `NDEF` = 5, keeping `SAMPLE_DIV` = 8, `KDEF` = 1 and `KW`/`NW` at their defaults. A conversion then takes 32 clocks instead of 1024, and the reset cycle length closes after five conversions instead of four thousand. This brings the reset value of N, several K values, N = 0/1 and the restart on N writes within a short run. The divider and counter structure is the same one the defaults build.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int NSTAT   = 2;
    localparam int ST_CONV = 0;
    localparam int ST_CYC  = 1;
endpackage

// File: rtl/cs_prescale.sv
module cs_prescale #(
    parameter int KW   = 8,
    parameter int KDEF = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_wr,
    input  logic [KW-1:0] k_wdata,
    output logic          tick
);
    typedef struct packed {
        logic [KW-1:0] k;
        logic [KW-1:0] cnt;
    } pre_t;

    pre_t          st_d, st_q;
    logic [KW-1:0] k_eff;

    always_comb begin
        k_eff = (st_q.k == '0) ? KW'(1) : st_q.k;
        tick  = !rst && (st_q.cnt >= k_eff - KW'(1));
        st_d  = st_q;
        if (rst) begin
            st_d.k   = KW'(KDEF);
            st_d.cnt = '0;
        end else if (k_wr) begin
            st_d.k   = k_wdata;
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + KW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/cs_rates.sv
module cs_rates #(
    parameter int SAMPLE_DIV = 8,
    parameter int WORD_DIV   = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic sample_stb,
    output logic conv_stb
);
    localparam int SUB_W  = $clog2(SAMPLE_DIV);
    localparam int TICK_W = $clog2(WORD_DIV);

    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        sample_stb = tick && (cnt_q[SUB_W-1:0] == SUB_W'(SAMPLE_DIV - 1));
        conv_stb   = tick && (cnt_q == TICK_W'(WORD_DIV - 1));
        cnt_d      = cnt_q;
        if (rst)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + TICK_W'(1);
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cs_cycle.sv
module cs_cycle #(
    parameter int NW   = 16,
    parameter int NDEF = 4000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_stb,
    input  logic          n_wr,
    input  logic [NW-1:0] n_wdata,
    output logic          cycle_stb
);
    typedef struct packed {
        logic [NW-1:0] n;
        logic [NW-1:0] cnt;
    } cyc_t;

    cyc_t          st_d, st_q;
    logic [NW-1:0] n_eff;

    always_comb begin
        n_eff     = (st_q.n == '0) ? NW'(1) : st_q.n;
        cycle_stb = conv_stb && (st_q.cnt >= n_eff - NW'(1));
        st_d      = st_q;
        if (rst) begin
            st_d.n   = NW'(NDEF);
            st_d.cnt = '0;
        end else if (n_wr) begin
            st_d.n   = n_wdata;
            st_d.cnt = '0;
        end else if (cycle_stb) begin
            st_d.cnt = '0;
        end else if (conv_stb) begin
            st_d.cnt = st_q.cnt + NW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/cs_status.sv
module cs_status
    import cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] set,
    input  logic             clr_wr,
    input  logic [NSTAT-1:0] clr_wdata,
    input  logic             mask_wr,
    input  logic [NSTAT-1:0] mask_wdata,
    output logic [NSTAT-1:0] status,
    output logic [NSTAT-1:0] irq_en,
    output logic             irq_n
);
    typedef struct packed {
        logic [NSTAT-1:0] stat;
        logic [NSTAT-1:0] mask;
        logic             irq_n;
    } sts_t;

    sts_t             st_d, st_q;
    logic [NSTAT-1:0] stat_nx;

    for (genvar b = 0; b < NSTAT; b++) begin : g_bit
        always_comb begin
            if (set[b])                     stat_nx[b] = 1'b1;
            else if (clr_wr && clr_wdata[b]) stat_nx[b] = 1'b0;
            else                             stat_nx[b] = st_q.stat[b];
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.stat  = '0;
            st_d.mask  = '0;
            st_d.irq_n = 1'b1;
        end else begin
            st_d.stat  = stat_nx;
            st_d.mask  = mask_wr ? mask_wdata : st_q.mask;
            st_d.irq_n = ~|(st_q.stat & st_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign status = st_q.stat;
    assign irq_en = st_q.mask;
    assign irq_n  = st_q.irq_n;
endmodule

// File: rtl/conversion_sequencer.sv
module conversion_sequencer
    import cs_pkg::*;
#(
    parameter int KW         = 8,
    parameter int NW         = 16,
    parameter int KDEF       = 1,
    parameter int NDEF       = 4000,
    parameter int SAMPLE_DIV = 8,
    parameter int WORD_DIV   = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_wr,
    input  logic [KW-1:0] k_wdata,
    input  logic          n_wr,
    input  logic [NW-1:0] n_wdata,
    input  logic          mask_wr,
    input  logic [1:0]    mask_wdata,
    input  logic          clr_wr,
    input  logic [1:0]    clr_wdata,
    output logic          sample_stb,
    output logic          conv_stb,
    output logic          cycle_stb,
    output logic [1:0]    status,
    output logic [1:0]    irq_en,
    output logic          irq_n
);
    logic             tick;
    logic [NSTAT-1:0] set_vec;

    cs_prescale #(.KW(KW), .KDEF(KDEF)) i_pre (
        .clk(clk), .rst(rst), .k_wr(k_wr), .k_wdata(k_wdata), .tick(tick)
    );

    cs_rates #(.SAMPLE_DIV(SAMPLE_DIV), .WORD_DIV(WORD_DIV)) i_rates (
        .clk(clk), .rst(rst), .tick(tick),
        .sample_stb(sample_stb), .conv_stb(conv_stb)
    );

    cs_cycle #(.NW(NW), .NDEF(NDEF)) i_cyc (
        .clk(clk), .rst(rst), .conv_stb(conv_stb),
        .n_wr(n_wr), .n_wdata(n_wdata), .cycle_stb(cycle_stb)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[ST_CONV] = conv_stb;
        set_vec[ST_CYC]  = cycle_stb;
    end

    cs_status i_sts (
        .clk(clk), .rst(rst), .set(set_vec),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .status(status), .irq_en(irq_en), .irq_n(irq_n)
    );
endmodule

// File: rtl/cs_checker.sv
module cs_checker (
    input logic       clk,
    input logic       rst,
    input logic       clr_wr,
    input logic [1:0] clr_wdata,
    input logic       sample_stb,
    input logic       conv_stb,
    input logic       cycle_stb,
    input logic [1:0] status,
    input logic [1:0] irq_en,
    input logic       irq_n
);
    // R2
    conv_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        conv_stb |-> sample_stb);

    // R3
    conv_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        conv_stb |=> status[0]);

    // R4
    cycle_on_conv_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_stb |-> conv_stb);

    // R4
    cycle_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_stb |=> status[1]);

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !(clr_wr && clr_wdata[0])) |=> status[0]);

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_wdata[1] && !cycle_stb) |=> !status[1]);

    // R8
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (|(status & irq_en)) |=> !irq_n);

    // R8
    irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(status & irq_en)) |=> irq_n);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status == 2'b00 && irq_en == 2'b00 && irq_n));
endmodule

bind conversion_sequencer cs_checker i_cs_checker (
    .clk(clk), .rst(rst), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .sample_stb(sample_stb), .conv_stb(conv_stb), .cycle_stb(cycle_stb),
    .status(status), .irq_en(irq_en), .irq_n(irq_n)
);

// File: tb/test_conversion_sequencer.sv
module test_conversion_sequencer;
    localparam int KW = 8, NW = 16, WDIV = 32, NDEF = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          k_wr = 1'b0, n_wr = 1'b0, mask_wr = 1'b0, clr_wr = 1'b0;
    logic [KW-1:0] k_wdata = '0;
    logic [NW-1:0] n_wdata = '0;
    logic [1:0]    mask_wdata = '0, clr_wdata = '0;
    logic          sample_stb, conv_stb, cycle_stb, irq_n;
    logic [1:0]    status, irq_en;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    conversion_sequencer #(.KW(KW), .NW(NW), .KDEF(1), .NDEF(NDEF),
                           .SAMPLE_DIV(8), .WORD_DIV(WDIV)) i_conversion_sequencer (
        .clk(clk), .rst(rst), .k_wr(k_wr), .k_wdata(k_wdata),
        .n_wr(n_wr), .n_wdata(n_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .sample_stb(sample_stb), .conv_stb(conv_stb), .cycle_stb(cycle_stb),
        .status(status), .irq_en(irq_en), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic stb(input int which);
        case (which)
            0:       return sample_stb;
            1:       return conv_stb;
            default: return cycle_stb;
        endcase
    endfunction

    // waits at negedges until the chosen strobe is high; returns clocks waited
    task automatic wait_stb(input int which, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!stb(which) && n < 20000);
    endtask

    task automatic wr_clr(input logic [1:0] v);
        clr_wr = 1'b1; clr_wdata = v;
        @(negedge clk);
        clr_wr = 1'b0;
    endtask

    task automatic wr_mask(input logic [1:0] v);
        mask_wr = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic wr_k(input logic [KW-1:0] v);
        k_wr = 1'b1; k_wdata = v;
        @(negedge clk);
        k_wr = 1'b0;
    endtask

    task automatic wr_n(input logic [NW-1:0] v);
        n_wr = 1'b1; n_wdata = v;
        @(negedge clk);
        n_wr = 1'b0;
    endtask

    // counts conversions up to and including the next cycle strobe
    task automatic count_convs(output int c);
        c = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (conv_stb) c++;
            if (cycle_stb) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 status", int'(status), 0);
        check("R9 irq_en", int'(irq_en), 0);
        check("R9 irq_n", int'(irq_n), 1);
    endtask

    task automatic t_default_n();
        int c;
        count_convs(c);
        check("R9 default N", c, NDEF);
        check("R4 cycle with conv", int'(conv_stb), 1);
        @(negedge clk);
        check("R4 status bit1 set", int'(status[1]), 1);
        count_convs(c);
        check("R4 next cycle length", c, NDEF);
    endtask

    task automatic t_rates(input int k);
        int n;
        if (k != 1) wr_k(KW'(k));
        wait_stb(0, n);
        wait_stb(0, n);
        check("R1 sample period", n, 8 * ((k == 0) ? 1 : k));
        wait_stb(1, n);
        wait_stb(1, n);
        check("R2 conv period", n, WDIV * ((k == 0) ? 1 : k));
        if (k != 1) wr_k(KW'(1));
    endtask

    task automatic t_conv_sets();
        int n;
        wait_stb(1, n);
        @(negedge clk);
        wr_clr(2'b11);
        check("R7 clear both", int'(status), 0);
        wait_stb(1, n);
        check("R3 not yet set", int'(status[0]), 0);
        @(negedge clk);
        check("R3 conv ready set", int'(status[0]), 1);
    endtask

    task automatic t_clear_per_bit();
        int c;
        count_convs(c);
        @(negedge clk);
        check("R7 both set", int'(status), 3);
        wr_clr(2'b01);
        check("R7 clear bit0 only", int'(status), 2);
        wr_clr(2'b10);
        check("R7 clear bit1", int'(status), 0);
    endtask

    task automatic t_set_wins();
        int n;
        wait_stb(1, n);
        clr_wr = 1'b1; clr_wdata = 2'b01;
        @(negedge clk);
        clr_wr = 1'b0;
        check("R7 set wins over clear", int'(status[0]), 1);
    endtask

    task automatic t_irq();
        int n;
        wait_stb(1, n);
        @(negedge clk);
        wr_clr(2'b11);
        wr_mask(2'b01);
        check("R8 mask loaded", int'(irq_en), 1);
        check("R8 irq idle", int'(irq_n), 1);
        wait_stb(1, n);
        @(negedge clk);
        check("R8 irq lags status", int'(irq_n), 1);
        @(negedge clk);
        check("R8 irq asserted", int'(irq_n), 0);
        wr_mask(2'b10);
        check("R8 irq still low", int'(irq_n), 0);
        @(negedge clk);
        check("R8 masked irq released", int'(irq_n), 1);
        wr_mask(2'b00);
    endtask

    task automatic t_n_small(input int nv);
        int c;
        wr_n(NW'(nv));
        for (int i = 0; i < 3; i++) begin
            count_convs(c);
            check("R5 every conversion", c, 1);
        end
    endtask

    task automatic t_n_restart();
        int n, c;
        wr_n(NW'(4));
        wait_stb(1, n);
        wait_stb(1, n);
        @(negedge clk);
        wr_n(NW'(3));
        count_convs(c);
        check("R6 restart count", c, 3);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_default_n();
        t_rates(1);
        t_rates(3);
        t_rates(0);
        t_conv_sets();
        t_clear_per_bit();
        t_set_wins();
        t_irq();
        t_n_small(1);
        t_n_small(0);
        t_n_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule